// File: doc/BRIEF.md
# Charge Status LED Pattern Driver

This block turns the charge status of two battery cells into blink patterns on two status LEDs. Each LED output is a drive-low enable for an open-drain pad. A set output pulls the pin low. A clear output releases it to high impedance. The pattern for each status depends on a display mode, which is decoded from a three-level select pin (low, open or high). All pattern timing is built from a slot of 0.16 s. The slot is counted in pulses of a fine timing tick.

The second LED pin also serves as a configuration strap. Right after reset the block enables a test pull-up on that pin and samples the pin level. It then enables a test pull-down and samples again. From the two samples it classifies the strap as low, open or high, which selects 1-cell series, 2-cell series or parallel charging. It latches this result and only then enables any LED drive. In series configuration the first LED shows the status shared by both cells and the second LED stays released. In parallel configuration each LED shows its own cell.

Top module: `led_status_blinker`

## Requirements
- R1: Both LED outputs are drive-low enables that only ever pull low. Both stay clear (released) from reset until the strap has been classified and `cfgValid` is set.
- R2: After reset, `strapPullUp` is high for SETTLE_CYC cycles. `strapPullDn` is then high for SETTLE_CYC cycles. The two are never high together. `cfgValid` rises 2*SETTLE_CYC clock edges after reset is released.
- R3: The strap is classified from the pull-up sample and the pull-down sample. Both low gives `chargeCfg` = 0 (1-cell series). Both high gives 2 (parallel). A pin that follows the pull gives 1 (2-cell series). Any other pair also gives 1. The value stays fixed until the next reset.
- R4: Status code 0 (no battery) leaves the LED released in every display mode.
- R5: Status code 3 (fault) repeats one slot low and one slot released in every display mode.
- R6: Status code 1 (charging) is steady low in DM0. In DM1 it repeats five slots low and one slot released. In DM2 it repeats three slots low and three slots released.
- R7: Status code 2 (maintenance) is released in DM0 and steady low in DM1 and DM2.
- R8: `dispSel` code 0 (pin low) selects DM0. Code 1 (pin open) selects DM1. Code 2 (pin high) selects DM2. Code 3 is treated as DM1.
- R9: One slot lasts SLOT_TICKS `tick` pulses. Every blinking pattern starts with its low portion.
- R10: A change of a cell's status code restarts that LED's pattern at the start of its first slot.
- R11: In series configuration (codes 0 and 1), `ledLowA` follows `cellStatA` and `ledLowB` stays released. In parallel configuration (code 2), each LED follows its own cell's status independently.
- R12: An output reflects a new status or display mode one clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; restarts strap sampling |
| tick | input | 1 | Fine timing pulse; SLOT_TICKS pulses make one 0.16 s slot |
| dispSel | input | 2 | Decoded select pin level: 0 low, 1 open, 2 high |
| cellStatA | input | 2 | Cell 1 status: 0 none, 1 charging, 2 maintenance, 3 fault |
| cellStatB | input | 2 | Cell 2 status, same coding |
| strapIn | input | 1 | Sampled logic level of the second LED pin |
| strapPullUp | output | 1 | Enables the test pull-up on the second LED pin |
| strapPullDn | output | 1 | Enables the test pull-down on the second LED pin |
| chargeCfg | output | 2 | Latched configuration: 0 1-cell series, 1 2-cell series, 2 parallel |
| cfgValid | output | 1 | Strap classified; LED drive enabled |
| ledLowA | output | 1 | Drive-low enable for LED 1 |
| ledLowB | output | 1 | Drive-low enable for LED 2 |

## Verification
A status or display-mode change is registered at the next clock edge. The new pattern, starting at slot zero, is therefore visible one edge later. A slot advances on the edge that takes the SLOT_TICKS-th tick pulse. The strap result and `cfgValid` appear 2*SETTLE_CYC edges after reset is released. The bench drives every input on the falling edge and samples on a later falling edge. During a pattern walk it holds the tick high and samples once every SLOT_TICKS cycles, so each sample falls in the middle of a known slot. It compares each sample against a 12-slot expected mask taken from the requirements.

// File: rtl/ledblink_pkg.sv
package ledblink_pkg;

  localparam int NUM_LED = 2;
  localparam int PHASE_W = 3;

  localparam logic [1:0] ST_NONE  = 2'd0;
  localparam logic [1:0] ST_CHG   = 2'd1;
  localparam logic [1:0] ST_MAINT = 2'd2;
  localparam logic [1:0] ST_FAULT = 2'd3;

  localparam logic [1:0] CFG_SER1 = 2'd0;
  localparam logic [1:0] CFG_SER2 = 2'd1;
  localparam logic [1:0] CFG_PAR  = 2'd2;

  localparam logic [1:0] DM0 = 2'd0;
  localparam logic [1:0] DM1 = 2'd1;
  localparam logic [1:0] DM2 = 2'd2;

  typedef struct packed {
    logic               drvEn;
    logic               series;
    logic [NUM_LED-1:0] restart;
    logic [NUM_LED-1:0] slotStep;
  } blink_strobe_t;

  typedef struct packed {
    logic [PHASE_W-1:0] onSlots;
    logic [PHASE_W-1:0] period;
  } blink_pat_t;

  function automatic logic [1:0] decodeMode(input logic [1:0] sel);
    case (sel)
      2'd0:    decodeMode = DM0;
      2'd2:    decodeMode = DM2;
      default: decodeMode = DM1;
    endcase
  endfunction

  function automatic logic [1:0] classifyStrap(input logic upLvl, input logic dnLvl);
    case ({upLvl, dnLvl})
      2'b00:   classifyStrap = CFG_SER1;
      2'b11:   classifyStrap = CFG_PAR;
      default: classifyStrap = CFG_SER2;
    endcase
  endfunction

  function automatic blink_pat_t patternOf(input logic [1:0] stat, input logic [1:0] mode);
    blink_pat_t p;
    p.onSlots = 3'd0;
    p.period  = 3'd1;
    case (stat)
      ST_FAULT: begin p.onSlots = 3'd1; p.period = 3'd2; end
      ST_CHG: begin
        if (mode == DM0)      begin p.onSlots = 3'd1; p.period = 3'd1; end
        else if (mode == DM2) begin p.onSlots = 3'd3; p.period = 3'd6; end
        else                  begin p.onSlots = 3'd5; p.period = 3'd6; end
      end
      ST_MAINT: begin
        if (mode == DM0) begin p.onSlots = 3'd0; p.period = 3'd1; end
        else             begin p.onSlots = 3'd1; p.period = 3'd1; end
      end
      default: begin p.onSlots = 3'd0; p.period = 3'd1; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ledblink_ctrl.sv
module ledblink_ctrl
  import ledblink_pkg::*;
#(
  parameter int SLOT_TICKS = 16,
  parameter int SETTLE_CYC = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic                     strapIn,
  input  logic [NUM_LED-1:0][1:0]  statIn,
  output logic                     strapPullUp,
  output logic                     strapPullDn,
  output logic [1:0]               chargeCfg,
  output logic                     cfgValid,
  output logic [NUM_LED-1:0][1:0]  statReg,
  output blink_strobe_t            strobe
);

  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int TICK_W = $clog2(SLOT_TICKS + 1);
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETTLE_CYC - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);

  typedef enum logic [1:0] {SP_UP, SP_DN, SP_RUN} strap_st_e;

  strap_st_e        spState;
  logic [SET_W-1:0] settleCnt;
  logic             upSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spState   <= SP_UP;
      settleCnt <= '0;
      upSample  <= 1'b0;
      chargeCfg <= CFG_SER1;
    end else begin
      case (spState)
        SP_UP: begin
          if (settleCnt == SET_LAST) begin
            upSample  <= strapIn;
            settleCnt <= '0;
            spState   <= SP_DN;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        SP_DN: begin
          if (settleCnt == SET_LAST) begin
            chargeCfg <= classifyStrap(upSample, strapIn);
            settleCnt <= '0;
            spState   <= SP_RUN;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign strapPullUp = (spState == SP_UP);
  assign strapPullDn = (spState == SP_DN);
  assign cfgValid    = (spState == SP_RUN);

  logic [NUM_LED-1:0] restartV;
  logic [NUM_LED-1:0] stepV;

  for (genvar gi = 0; gi < NUM_LED; gi++) begin : g_slot
    logic [TICK_W-1:0] tickCnt;

    assign restartV[gi] = (statIn[gi] != statReg[gi]);
    assign stepV[gi]    = tick && (tickCnt == TICK_LAST) && !restartV[gi];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statReg[gi] <= ST_NONE;
        tickCnt     <= '0;
      end else begin
        statReg[gi] <= statIn[gi];
        if (restartV[gi])   tickCnt <= '0;
        else if (stepV[gi]) tickCnt <= '0;
        else if (tick)      tickCnt <= tickCnt + 1'b1;
      end
    end

    // R9
    tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickCnt <= TICK_LAST);
  end

  assign strobe = '{drvEn: cfgValid, series: (chargeCfg != CFG_PAR),
                    restart: restartV, slotStep: stepV};

  // R2
  no_dual_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strapPullUp && strapPullDn));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && $past(cfgValid)) |-> $stable(chargeCfg));

  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

endmodule

// File: rtl/ledblink_dp.sv
module ledblink_dp
  import ledblink_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  blink_strobe_t            strobe,
  input  logic [NUM_LED-1:0][1:0]  statReg,
  input  logic [1:0]               dispSel,
  output logic [NUM_LED-1:0]       ledLow
);

  logic [1:0] modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= DM0;
    else       modeReg <= decodeMode(dispSel);
  end

  for (genvar gi = 0; gi < NUM_LED; gi++) begin : g_led
    logic [PHASE_W-1:0] phase;
    blink_pat_t         pat;
    logic               patOn;

    assign pat   = patternOf(statReg[gi], modeReg);
    assign patOn = (phase < pat.onSlots);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phase <= '0;
      end else if (strobe.restart[gi]) begin
        phase <= '0;
      end else if (strobe.slotStep[gi]) begin
        if (phase >= pat.period - 3'd1) phase <= '0;
        else                            phase <= phase + 3'd1;
      end
    end

    if (gi == 0) begin : g_first
      assign ledLow[gi] = strobe.drvEn && patOn;
    end else begin : g_other
      assign ledLow[gi] = strobe.drvEn && !strobe.series && patOn;
    end

    // R9
    phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      phase < 3'd6);

    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.restart[gi] |=> (phase == '0));

    // R4
    none_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statReg[gi] == ST_NONE) |-> !ledLow[gi]);
  end

endmodule

// File: rtl/led_status_blinker.sv
module led_status_blinker
  import ledblink_pkg::*;
#(
  parameter int SLOT_TICKS = 16,
  parameter int SETTLE_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] dispSel,
  input  logic [1:0] cellStatA,
  input  logic [1:0] cellStatB,
  input  logic       strapIn,
  output logic       strapPullUp,
  output logic       strapPullDn,
  output logic [1:0] chargeCfg,
  output logic       cfgValid,
  output logic       ledLowA,
  output logic       ledLowB
);

  blink_strobe_t            strobe;
  logic [NUM_LED-1:0][1:0]  statIn;
  logic [NUM_LED-1:0][1:0]  statReg;
  logic [NUM_LED-1:0]       ledLow;

  assign statIn[0] = cellStatA;
  assign statIn[1] = cellStatB;

  ledblink_ctrl #(
    .SLOT_TICKS(SLOT_TICKS),
    .SETTLE_CYC(SETTLE_CYC)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .strapIn    (strapIn),
    .statIn     (statIn),
    .strapPullUp(strapPullUp),
    .strapPullDn(strapPullDn),
    .chargeCfg  (chargeCfg),
    .cfgValid   (cfgValid),
    .statReg    (statReg),
    .strobe     (strobe)
  );

  ledblink_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .statReg(statReg),
    .dispSel(dispSel),
    .ledLow (ledLow)
  );

  assign ledLowA = ledLow[0];
  assign ledLowB = ledLow[1];

  // R1
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strapPullUp || strapPullDn) |-> (!ledLowA && !ledLowB));

  // R11
  series_b_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && chargeCfg != CFG_PAR) |-> !ledLowB);

endmodule

// File: tb/sim_led_status_blinker.sv
`timescale 1ns/1ps
module sim_led_status_blinker;

  localparam int SLOT = 4;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] dispSel = 2'd0;
  logic [1:0] cellStatA = 2'd0;
  logic [1:0] cellStatB = 2'd0;
  logic       strapIn;
  logic       strapPullUp, strapPullDn, cfgValid, ledLowA, ledLowB;
  logic [1:0] chargeCfg;
  int         strapKind = 2;
  int         nRun = 0;
  int         nFail = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  // strap kinds: 0 tied low, 1 open (follows pull), 2 tied high, 3 opposes pull
  always_comb begin
    case (strapKind)
      0:       strapIn = 1'b0;
      2:       strapIn = 1'b1;
      3:       strapIn = strapPullDn;
      default: strapIn = strapPullUp;
    endcase
  end

  led_status_blinker #(.SLOT_TICKS(SLOT), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .dispSel(dispSel),
    .cellStatA(cellStatA), .cellStatB(cellStatB), .strapIn(strapIn),
    .strapPullUp(strapPullUp), .strapPullDn(strapPullDn), .chargeCfg(chargeCfg),
    .cfgValid(cfgValid), .ledLowA(ledLowA), .ledLowB(ledLowB));

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string req, input string what);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  // Reset with a given strap, watch the sampling sequence, check the result.
  task automatic doReset(input int kind, input logic [1:0] expCfg, input string req);
    bit sawUp, sawDn, sawBoth, sawLed;
    int upLen, dnLen;
    @(negedge clk);
    rstN = 1'b0; strapKind = kind; tick = 1'b0;
    cellStatA = 2'd1; cellStatB = 2'd1; dispSel = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sawUp = 0; sawDn = 0; sawBoth = 0; sawLed = 0; upLen = 0; dnLen = 0;
    for (int i = 0; i < 2 * SETTLE; i++) begin
      if (strapPullUp) begin sawUp = 1; upLen++; end
      if (strapPullDn) begin sawDn = 1; dnLen++; end
      if (strapPullUp && strapPullDn) sawBoth = 1;
      if (ledLowA || ledLowB || cfgValid) sawLed = 1;
      @(negedge clk);
    end
    check({3'b0, sawBoth}, 4'd0, "R2", "pull-up and pull-down together");
    check(upLen[3:0], 4'(SETTLE), "R2", "pull-up length");
    check(dnLen[3:0], 4'(SETTLE), "R2", "pull-down length");
    check({3'b0, sawLed}, 4'd0, "R1", "drive or valid before classification");
    check({3'b0, cfgValid}, 4'd1, "R2", "cfgValid after sampling");
    check({2'b0, chargeCfg}, {2'b0, expCfg}, req, "strap classification");
    cellStatA = 2'd0; cellStatB = 2'd0;
    @(negedge clk);
  endtask

  // Walk 12 slots with tick held high, comparing both LEDs to expected masks.
  task automatic walk(input logic [11:0] maskA, input logic [11:0] maskB, input string req);
    for (int s = 0; s < 12; s++) begin
      check({3'b0, ledLowA}, {3'b0, maskA[s]}, req, $sformatf("LED A slot %0d", s));
      check({3'b0, ledLowB}, {3'b0, maskB[s]}, req, $sformatf("LED B slot %0d", s));
      tick = 1'b1;
      repeat (SLOT) @(negedge clk);
    end
    tick = 1'b0;
  endtask

  // {dispSel, status, expected mask over 12 slots}
  localparam logic [15:0] VEC [13] = '{
    {2'd0, 2'd0, 12'h000}, {2'd0, 2'd1, 12'hFFF}, {2'd0, 2'd2, 12'h000}, {2'd0, 2'd3, 12'h555},
    {2'd1, 2'd0, 12'h000}, {2'd1, 2'd1, 12'h7DF}, {2'd1, 2'd2, 12'hFFF}, {2'd1, 2'd3, 12'h555},
    {2'd2, 2'd0, 12'h000}, {2'd2, 2'd1, 12'h1C7}, {2'd2, 2'd2, 12'hFFF}, {2'd2, 2'd3, 12'h555},
    {2'd3, 2'd1, 12'h7DF}
  };
  localparam string VREQ [13] = '{"R4", "R6", "R7", "R5", "R4", "R6", "R7", "R5",
                                  "R4", "R6", "R7", "R5", "R8"};

  initial begin
    // R3 parallel strap, R1/R2 sequencing
    doReset(2, 2'd2, "R3");

    // Table walk in parallel mode: R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 13; v++) begin
      cellStatA = 2'd0; cellStatB = 2'd0;
      @(negedge clk);
      dispSel = VEC[v][15:14];
      cellStatA = VEC[v][13:12];
      @(negedge clk);
      walk(VEC[v][11:0], 12'h000, VREQ[v]);
    end

    // R11 parallel independence: A charging in DM2, B fault
    cellStatA = 2'd0; @(negedge clk);
    dispSel = 2'd2; cellStatA = 2'd1; cellStatB = 2'd3;
    @(negedge clk);
    walk(12'h1C7, 12'h555, "R11");

    // R10 restart: move A into an off slot, then change status to fault
    cellStatA = 2'd0; cellStatB = 2'd0; @(negedge clk);
    cellStatA = 2'd1; @(negedge clk);
    tick = 1'b1; repeat (4 * SLOT) @(negedge clk); tick = 1'b0;
    check({3'b0, ledLowA}, 4'd0, "R10", "DM2 charging in slot 4");
    cellStatA = 2'd3;
    @(negedge clk);
    walk(12'h555, 12'h000, "R10");

    // R12 display mode change latency: maintenance DM1 -> DM0
    cellStatA = 2'd2; dispSel = 2'd1; @(negedge clk);
    check({3'b0, ledLowA}, 4'd1, "R12", "maintenance DM1 one edge after");
    dispSel = 2'd0; @(negedge clk);
    check({3'b0, ledLowA}, 4'd0, "R12", "maintenance DM0 one edge after");

    // R11 series configuration: B released, A follows cell A
    doReset(0, 2'd0, "R3");
    dispSel = 2'd0; cellStatA = 2'd1; cellStatB = 2'd3;
    @(negedge clk);
    walk(12'hFFF, 12'h000, "R11");

    // R3 open strap and strap opposing the pull
    doReset(1, 2'd1, "R3");
    dispSel = 2'd2; cellStatA = 2'd3; cellStatB = 2'd1;
    @(negedge clk);
    walk(12'h555, 12'h000, "R11");
    doReset(3, 2'd1, "R3");

    finishRun();
  end

endmodule